// File: doc/BRIEF.md
# Lane Transmit Equalization Controller

This block governs the transmit cursor setting of one serial lane. A link controller sends it a 2-bit command. The command can do one of three things: apply one of eleven stored presets, load three custom cursor values, or simply ask for the current setting. The block holds an 18-bit cursor register and shows it on a status output. It also reports two fixed driver characteristics: full swing and low frequency. Each finished command produces a done pulse that lasts one cycle.

The command, preset and coefficient pins are plain level-sampled control inputs. They carry no valid/ready handshake and exert no back-pressure. The requester paces itself. It presents a command, waits for done, and then drives the command back to idle. Until it does so, the block ignores any non-idle code. A 3-bit state output lets a debugger follow the sequencer.

Top module: `eqctl_lane`

## Requirements
- R1: After reset, `fsm_state_dbg` is 0, `eq_done` is 0, and `cursor_status` holds preset 4, which is 18'h00C00.
- R2: The commands are 00 idle, 01 preset, 10 custom, and 11 query. `fsm_state_dbg` uses 0 idle, 1 preset, 2 coeff, 3 remap, 4 query and 5 done. For a preset the block steps through the states 1, 3, 5, one state per clock.
- R3: A preset command with a valid code loads the table entry into `cursor_status` in the cycle in which `eq_done` is high. That cycle is the third clock after the command is accepted.
- R4: A preset code from 11 to 15 is reserved. It leaves `cursor_status` unchanged, but `eq_done` still pulses in the same cycle as for a valid code.
- R5: A custom load reads `coeff_in` on three consecutive clocks, starting with the clock that accepts command 10. The first clock gives the pre-cursor, the second the main cursor and the third the post-cursor. The state is 2 during the load, and `eq_done` rises after the third clock.
- R6: `cursor_status` places the pre-cursor in bits 17:12, the main cursor in bits 11:6 and the post-cursor in bits 5:0.
- R7: `eq_done` is never high for two consecutive cycles.
- R8: After done, a non-idle command that stays on the pins starts nothing. There is no new done pulse and the cursor does not change. The next command is accepted only after the command has been 00 for at least one clock.
- R9: `preset_sel` is sampled only on the clock that accepts command 01. Changes to it later in the operation, and any value on `coeff_in` during a preset, have no effect.
- R10: A query passes from state 4 to state 5, pulses done on the second clock, and leaves the cursor unchanged.
- R11: The presets give (pre, main, post) as follows. 0: (0,36,12), 1: (0,40,8), 2: (0,38,10), 3: (0,42,6), 4: (0,48,0), 5: (6,42,0), 6: (8,40,0), 7: (6,32,10), 8: (6,36,6), 9: (10,38,0), 10: (0,32,16). At the default full swing, each entry sums to 48.
- R12: `full_swing` is a constant 48 and `low_freq` is a constant 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst | input | 1 | Synchronous reset, active high |
| eq_cmd | input | 2 | Command code |
| preset_sel | input | 4 | Preset number, read when a preset command is accepted |
| coeff_in | input | 6 | Serial cursor value for custom loads |
| full_swing | output | 6 | Fixed full-swing value |
| low_freq | output | 6 | Fixed low-frequency value |
| cursor_status | output | 18 | Active cursors: pre, main, post |
| eq_done | output | 1 | Single-cycle completion pulse |
| fsm_state_dbg | output | 3 | Sequencer state code |

## Verification
All eleven valid presets are applied, each followed by a scoreboard comparison. Later preset codes and noise on the coefficient bus are changed during each run, which separates a block that samples at acceptance from one that samples too late. Reserved codes 11 and 15 are mixed in between valid presets, so that a result which only looks unchanged cannot pass. The custom loads use three distinct values, which shows whether the beat order or the field placement is wrong. Commands are also held on the pins after done, which exposes a block that retriggers itself.

// File: rtl/eqctl_pkg.sv
package eqctl_pkg;
  localparam int CMD_W       = 2;
  localparam int NUM_CURSORS = 3;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PRESET = 3'd1,
    ST_COEFF  = 3'd2,
    ST_REMAP  = 3'd3,
    ST_QUERY  = 3'd4,
    ST_DONE   = 3'd5
  } eq_state_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE   = 2'b00,
    CMD_PRESET = 2'b01,
    CMD_COEFF  = 2'b10,
    CMD_QUERY  = 2'b11
  } eq_cmd_e;
endpackage

// File: rtl/eqctl_preset_rom.sv
module eqctl_preset_rom #(
  parameter int CUR_W          = 6,
  parameter int PRESET_W       = 4,
  parameter int NUM_PRESETS    = 11,
  parameter int DEFAULT_PRESET = 4,
  parameter int FS_VAL         = 48
) (
  input  logic [PRESET_W-1:0]  code_i,
  output logic [3*CUR_W-1:0]   word_o,
  output logic                 valid_o,
  output logic [3*CUR_W-1:0]   dflt_o
);
  localparam int REF_FS = 48;

  function automatic logic [CUR_W-1:0] sc(input int unsigned v);
    return CUR_W'((v * FS_VAL) / REF_FS);
  endfunction

  function automatic logic [3*CUR_W-1:0] lookup(input int idx);
    case (idx)
      0:       return {sc(0),  sc(36), sc(12)};
      1:       return {sc(0),  sc(40), sc(8)};
      2:       return {sc(0),  sc(38), sc(10)};
      3:       return {sc(0),  sc(42), sc(6)};
      4:       return {sc(0),  sc(48), sc(0)};
      5:       return {sc(6),  sc(42), sc(0)};
      6:       return {sc(8),  sc(40), sc(0)};
      7:       return {sc(6),  sc(32), sc(10)};
      8:       return {sc(6),  sc(36), sc(6)};
      9:       return {sc(10), sc(38), sc(0)};
      10:      return {sc(0),  sc(32), sc(16)};
      default: return '0;
    endcase
  endfunction

  assign word_o  = lookup(int'(code_i));
  assign valid_o = int'(code_i) < NUM_PRESETS;
  assign dflt_o  = lookup(DEFAULT_PRESET);
endmodule

// File: rtl/eqctl_coeff_deser.sv
module eqctl_coeff_deser #(
  parameter int W     = 6,
  parameter int BEATS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             active_i,
  input  logic [W-1:0]     data_i,
  output logic             last_o,
  output logic [W*BEATS-1:0] word_o
);
  localparam int ACC_W = W * (BEATS - 1);
  localparam int CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1;

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;

  assign last_o = active_i && (cnt_q == CNT_W'(BEATS - 1));
  assign word_o = {acc_q, data_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      acc_q <= ACC_W'(data_i);
      cnt_q <= CNT_W'(1);
    end else if (active_i && !last_o) begin
      acc_q <= (acc_q << W) | ACC_W'(data_i);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: while loading, the beat counter stays within the middle beats
  p_beat_range_r5: assert property (@(posedge clk) disable iff (rst)
    active_i |-> (cnt_q != '0) && (cnt_q <= CNT_W'(BEATS - 1)));
endmodule

// File: rtl/eqctl_fsm.sv
module eqctl_fsm
  import eqctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             coeff_last_i,
  output eq_state_e        state_o,
  output logic             accept_o
);
  eq_state_e state_q, state_d;
  logic      need_idle_q;

  assign accept_o = (state_q == ST_IDLE) && !need_idle_q && (cmd_i != CMD_IDLE);
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept_o) begin
        case (cmd_i)
          CMD_PRESET: state_d = ST_PRESET;
          CMD_COEFF:  state_d = ST_COEFF;
          default:    state_d = ST_QUERY;
        endcase
      end
      ST_PRESET: state_d = ST_REMAP;
      ST_REMAP:  state_d = ST_DONE;
      ST_COEFF:  if (coeff_last_i) state_d = ST_DONE;
      ST_QUERY:  state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      need_idle_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DONE) need_idle_q <= (cmd_i != CMD_IDLE);
      else                    need_idle_q <= need_idle_q && (cmd_i != CMD_IDLE);
    end
  end

  // R8: a command left on the pins after done keeps the sequencer idle
  p_no_retrigger_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE && cmd_i != CMD_IDLE) |=> (state_q == ST_IDLE) && !accept_o);
  // R2: remap is reached only through the preset state
  p_remap_path_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REMAP) |-> ($past(state_q) == ST_PRESET));
  // R2: done follows only remap, the final coefficient beat, or query
  p_done_path_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |-> ($past(state_q) inside {ST_REMAP, ST_COEFF, ST_QUERY}));
endmodule

// File: rtl/eqctl_lane.sv
module eqctl_lane
  import eqctl_pkg::*;
#(
  parameter int CUR_W          = 6,
  parameter int PRESET_W       = 4,
  parameter int NUM_PRESETS    = 11,
  parameter int DEFAULT_PRESET = 4,
  parameter int FS_VAL         = 48,
  parameter int LF_VAL         = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CMD_W-1:0]             eq_cmd,
  input  logic [PRESET_W-1:0]          preset_sel,
  input  logic [CUR_W-1:0]             coeff_in,
  output logic [CUR_W-1:0]             full_swing,
  output logic [CUR_W-1:0]             low_freq,
  output logic [NUM_CURSORS*CUR_W-1:0] cursor_status,
  output logic                         eq_done,
  output logic [2:0]                   fsm_state_dbg
);
  localparam int CURSOR_W = NUM_CURSORS * CUR_W;

  eq_state_e           state;
  logic                accept;
  logic                coeff_last;
  logic [CURSOR_W-1:0] coeff_word;
  logic [CURSOR_W-1:0] rom_word, rom_dflt;
  logic                rom_valid;
  logic [PRESET_W-1:0] preset_q;
  logic [CURSOR_W-1:0] rom_word_q;
  logic                rom_valid_q;
  logic [CURSOR_W-1:0] cursor_q;

  eqctl_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cmd_i        (eq_cmd),
    .coeff_last_i (coeff_last),
    .state_o      (state),
    .accept_o     (accept)
  );

  eqctl_coeff_deser #(.W(CUR_W), .BEATS(NUM_CURSORS)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .start_i  (accept && eq_cmd == CMD_COEFF),
    .active_i (state == ST_COEFF),
    .data_i   (coeff_in),
    .last_o   (coeff_last),
    .word_o   (coeff_word)
  );

  eqctl_preset_rom #(
    .CUR_W(CUR_W), .PRESET_W(PRESET_W), .NUM_PRESETS(NUM_PRESETS),
    .DEFAULT_PRESET(DEFAULT_PRESET), .FS_VAL(FS_VAL)
  ) u_rom (
    .code_i  (preset_q),
    .word_o  (rom_word),
    .valid_o (rom_valid),
    .dflt_o  (rom_dflt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      preset_q    <= PRESET_W'(DEFAULT_PRESET);
      rom_word_q  <= '0;
      rom_valid_q <= 1'b0;
      cursor_q    <= rom_dflt;
    end else begin
      if (accept && eq_cmd == CMD_PRESET) preset_q <= preset_sel;
      if (state == ST_PRESET) begin
        rom_word_q  <= rom_word;
        rom_valid_q <= rom_valid;
      end
      if (state == ST_REMAP && rom_valid_q) cursor_q <= rom_word_q;
      else if (coeff_last)                  cursor_q <= coeff_word;
    end
  end

  assign full_swing    = CUR_W'(FS_VAL);
  assign low_freq      = CUR_W'(LF_VAL);
  assign cursor_status = cursor_q;
  assign eq_done       = (state == ST_DONE);
  assign fsm_state_dbg = state;

  // R7: the completion pulse lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    eq_done |=> !eq_done);
  // R4: a reserved code leaves the cursor register alone
  p_reserved_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REMAP && !rom_valid_q) |=> $stable(cursor_status));
  // R10: a query never writes the cursor register
  p_query_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_QUERY) |=> $stable(cursor_status));
  // R3: the cursor changes only out of remap or the last coefficient beat
  p_cursor_write_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cursor_status) |-> ($past(state) inside {ST_REMAP, ST_COEFF}));
endmodule

// File: tb/eqctl_lane_tb.sv
module eqctl_lane_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  eq_cmd = 2'b00;
  logic [3:0]  preset_sel = 4'd0;
  logic [5:0]  coeff_in = 6'd0;
  logic [5:0]  full_swing, low_freq;
  logic [17:0] cursor_status;
  logic        eq_done;
  logic [2:0]  fsm_state_dbg;

  int checks = 0;
  int errors = 0;
  logic [17:0] exp_q[$];
  logic [17:0] model;
  logic        prev_done = 1'b0;
  logic        finished = 1'b0;

  always #2.5 clk = ~clk;

  eqctl_lane u_dut (
    .clk(clk), .rst(rst), .eq_cmd(eq_cmd), .preset_sel(preset_sel),
    .coeff_in(coeff_in), .full_swing(full_swing), .low_freq(low_freq),
    .cursor_status(cursor_status), .eq_done(eq_done), .fsm_state_dbg(fsm_state_dbg)
  );

  function automatic logic [17:0] tbl(input int c);
    case (c)
      0: return {6'd0, 6'd36, 6'd12};   1: return {6'd0, 6'd40, 6'd8};
      2: return {6'd0, 6'd38, 6'd10};   3: return {6'd0, 6'd42, 6'd6};
      4: return {6'd0, 6'd48, 6'd0};    5: return {6'd6, 6'd42, 6'd0};
      6: return {6'd8, 6'd40, 6'd0};    7: return {6'd6, 6'd32, 6'd10};
      8: return {6'd6, 6'd36, 6'd6};    9: return {6'd10, 6'd38, 6'd0};
      10: return {6'd0, 6'd32, 6'd16};
      default: return 18'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (eq_done) begin
        if (exp_q.size() == 0) chk(0, "R7 unexpected done", 1, 0);
        else begin
          logic [17:0] e;
          e = exp_q.pop_front();
          chk(cursor_status == e, "R3/R5/R6 cursor at done", cursor_status, e);
        end
        chk(!prev_done, "R7 done width", prev_done, 0);
      end
      prev_done = eq_done;
    end
  end

  task automatic release_cmd(input int hold);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(!eq_done && fsm_state_dbg == 3'd0, "R8 no retrigger", {fsm_state_dbg, eq_done}, 0);
      chk(cursor_status == model, "R8 cursor held", cursor_status, model);
      coeff_in = coeff_in + 6'd5;
      preset_sel = preset_sel + 4'd1;
    end
    eq_cmd = 2'b00;
  endtask

  task automatic do_preset(input int code, input int late, input int hold);
    @(negedge clk);
    eq_cmd = 2'b01; preset_sel = 4'(code); coeff_in = 6'h3F;
    if (code <= 10) model = tbl(code);
    exp_q.push_back(model);
    @(negedge clk);
    preset_sel = 4'(late); coeff_in = 6'h15;
    chk(fsm_state_dbg == 3'd1, "R2 preset state", fsm_state_dbg, 1);
    @(negedge clk);
    chk(fsm_state_dbg == 3'd3, "R2 remap state", fsm_state_dbg, 3);
    chk(!eq_done, "R3 done not early", eq_done, 0);
    @(negedge clk);
    chk(fsm_state_dbg == 3'd5 && eq_done, "R2 done state", {fsm_state_dbg, eq_done}, 11);
    if (code <= 10) begin
      chk(cursor_status[17:12] + cursor_status[11:6] + cursor_status[5:0] == 48,
          "R11 sum equals full swing",
          cursor_status[17:12] + cursor_status[11:6] + cursor_status[5:0], 48);
      chk(cursor_status == tbl(code), "R9 R11 preset entry", cursor_status, tbl(code));
    end else begin
      chk(cursor_status == model, "R4 reserved keeps cursor", cursor_status, model);
    end
    release_cmd(hold);
  endtask

  task automatic do_coeff(input logic [5:0] a, input logic [5:0] b, input logic [5:0] c, input int hold);
    @(negedge clk);
    eq_cmd = 2'b10; coeff_in = a;
    model = {a, b, c};
    exp_q.push_back(model);
    @(negedge clk);
    coeff_in = b;
    chk(fsm_state_dbg == 3'd2, "R5 coeff state beat2", fsm_state_dbg, 2);
    @(negedge clk);
    coeff_in = c;
    chk(fsm_state_dbg == 3'd2 && !eq_done, "R5 coeff state beat3", fsm_state_dbg, 2);
    @(negedge clk);
    coeff_in = 6'h2A;
    chk(eq_done && fsm_state_dbg == 3'd5, "R5 done after third beat", {fsm_state_dbg, eq_done}, 11);
    chk(cursor_status[17:12] == a && cursor_status[11:6] == b && cursor_status[5:0] == c,
        "R6 field placement", cursor_status, {a, b, c});
    release_cmd(hold);
  endtask

  task automatic do_query(input int hold);
    @(negedge clk);
    eq_cmd = 2'b11; coeff_in = 6'h11; preset_sel = 4'd7;
    exp_q.push_back(model);
    @(negedge clk);
    chk(fsm_state_dbg == 3'd4 && !eq_done, "R10 query state", fsm_state_dbg, 4);
    @(negedge clk);
    chk(eq_done && fsm_state_dbg == 3'd5, "R10 query done", {fsm_state_dbg, eq_done}, 11);
    chk(cursor_status == model, "R10 cursor unchanged", cursor_status, model);
    release_cmd(hold);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=0x1 expected=0x0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model = tbl(4);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(fsm_state_dbg == 3'd0, "R1 reset state", fsm_state_dbg, 0);
    chk(!eq_done, "R1 reset done low", eq_done, 0);
    chk(cursor_status == 18'h00C00, "R1 reset cursor", cursor_status, 18'h00C00);
    chk(full_swing == 6'd48, "R12 full swing", full_swing, 48);
    chk(low_freq == 6'd16, "R12 low frequency", low_freq, 16);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(fsm_state_dbg == 3'd0 && !eq_done, "R2 idle command", fsm_state_dbg, 0);
    end
    for (int p = 0; p <= 10; p++) begin
      do_preset(p, (p + 5) % 11, 0);
      if (p == 3) do_preset(11, 2, 0);
      if (p == 7) do_preset(15, 0, 0);
    end
    do_coeff(6'd3, 6'd41, 6'd4, 0);
    do_preset(12, 1, 0);
    do_coeff(6'd63, 6'd0, 6'd21, 3);
    do_query(0);
    do_preset(9, 10, 4);
    do_query(2);
    do_coeff(6'd1, 6'd2, 6'd3, 0);
    do_preset(6, 0, 0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all expected dones seen", exp_q.size(), 0);
    chk(full_swing == 6'd48 && low_freq == 6'd16, "R12 constants stable", {full_swing, low_freq}, {6'd48, 6'd16});
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule